// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits between a synchronous request source and an external 16-bit pseudo-SRAM that uses the classic asynchronous SRAM control style. It has active-low chip enable, output enable, write enable and one strobe for each byte lane. After reset the controller holds the memory deselected for a programmable settling interval. When that interval ends it accepts single-word requests on a valid/ready port. Each request carries a direction, a word address, write data and a two-bit byte-enable mask.

For each accepted request the controller places the address and lane strobes on the bus one cycle ahead of the active strobe. It holds chip enable together with output enable (for a read) or write enable (for a write) low for a parameter-set number of cycles, then raises every strobe on the same edge. Read data is captured on that edge and returned with a one-cycle valid pulse. Disabled lanes read as zero. The shared data bus is driven only while a write is in flight. A request with an empty mask never touches the memory.

Top module: `psram_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low and `mem_ce_n` stays high for PWRUP_CYC cycles; `req_ready` first goes high PWRUP_CYC cycles after the last reset cycle.
- R2: During reset and while idle, all five strobes are high and `rsp_valid` is low.
- R3: For a read accepted on edge a, `mem_addr` and the lane strobes are set after edge a. `mem_ce_n` and `mem_oe_n` are low after edges a+1 through a+RD_CYC, and `mem_we_n` stays high. `mem_addr` holds its value until the strobes rise.
- R4: The read word is sampled on the edge that raises the strobes (a+RD_CYC+1), and `rsp_valid` is high for exactly the cycle after that edge with that word on `rsp_rdata`. A lane whose enable is clear returns zero.
- R5: For a write, `mem_ce_n` and `mem_we_n` are low after edges a+1 through a+WR_CYC, and `mem_oe_n` stays high for the whole access.
- R6: A write ends by raising `mem_we_n`, `mem_ce_n` and the lane strobes on one edge. `mem_addr` and the driven data stay unchanged for the cycle after that edge.
- R7: `mem_lb_n` (bits 7:0) is low during an access only if `req_be[0]` was set, and `mem_ub_n` (bits 15:8) only if `req_be[1]` was set.
- R8: After every access all strobes are high for at least one cycle. `req_ready` is low from acceptance until two cycles after the strobes rise.
- R9: The controller drives `mem_dq` only from acceptance of a write until one cycle after its strobes rise; at all other times the bus is released.
- R10: A request with `req_be` = 0 leaves `mem_ce_n` high and keeps `req_ready` high. A read of this kind gives `rsp_valid` in the next cycle with `rsp_rdata` = 0; a write of this kind leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench holds a request pending through the whole settling interval. A controller that counts the interval short, or that accepts early, shows a strobe edge or a ready rise too soon. Single-lane writes to a word already written catch swapped or always-on lane strobes, because the untouched half of the word then reads back corrupted. The bench's memory model commits a write only on the rising strobe and only with the data present at that moment, so data released before the strobes rise gives stale read-back. Requests with an empty mask, and requests issued back to back with `req_valid` held, expose a controller that strobes the memory anyway, stalls, or leaves no idle gap between accesses.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/psram_powerup.sv
module psram_powerup #(
  parameter int PWRUP_CYC = 18750
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = (PWRUP_CYC < 2) ? 1 : $clog2(PWRUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PWRUP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int RD_CYC = 9,
  parameter int WR_CYC = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pu_done,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output logic             take,
  output logic             null_rd,
  output logic             rd_cap,
  output logic             rsp_valid,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_oe
);
  localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          accept;
  logic          last;

  assign req_ready = (state == ST_IDLE) && pu_done;
  assign accept    = req_ready && req_valid;
  assign take      = accept && (|req_be);
  assign null_rd   = accept && !(|req_be) && !req_write;
  assign last      = (state == ST_ACTIVE) && (cnt == '0);
  assign rd_cap    = last && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      lane_n    <= '1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= null_rd | rd_cap;
      case (state)
        ST_IDLE: begin
          if (take) begin
            wr_q   <= req_write;
            lane_n <= ~req_be;
            dq_oe  <= req_write;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          ce_n  <= 1'b0;
          oe_n  <= wr_q;
          we_n  <= !wr_q;
          cnt   <= wr_q ? WR_LOAD : RD_LOAD;
          state <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (last) begin
            ce_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            lane_n <= '1;
            state  <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          dq_oe <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/psram_datapath.sv
module psram_datapath
  import psram_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              rd_cap,
  input  logic              null_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata
);
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] cap_word;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cap_word[l*LANE_W +: LANE_W] = be_q[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      rdata    <= '0;
    end else begin
      if (take) begin
        mem_addr <= req_addr;
        wdata_q  <= req_wdata;
        be_q     <= req_be;
      end
      if (rd_cap)       rdata <= cap_word;
      else if (null_rd) rdata <= '0;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int DEPTH_WORDS = 1048576,
  parameter int PWRUP_CYC   = 18750,
  parameter int RD_CYC      = 9,
  parameter int WR_CYC      = 7,
  localparam int ADDR_W     = $clog2(DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  inout  wire  [15:0]       mem_dq
);
  logic              pu_done;
  logic              take;
  logic              null_rd;
  logic              rd_cap;
  logic              dq_oe;
  logic [LANES-1:0]  lane_n;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] dq_in;

  psram_powerup #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
    .clk (clk),
    .rst (rst),
    .done(pu_done)
  );

  psram_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .pu_done  (pu_done),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_be   (req_be),
    .req_ready(req_ready),
    .take     (take),
    .null_rd  (null_rd),
    .rd_cap   (rd_cap),
    .rsp_valid(rsp_valid),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .lane_n   (lane_n),
    .dq_oe    (dq_oe)
  );

  psram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .rd_cap   (rd_cap),
    .null_rd  (null_rd),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .dq_in    (dq_in),
    .mem_addr (mem_addr),
    .wdata_q  (wdata_q),
    .rdata    (rsp_rdata)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];
  assign mem_dq   = dq_oe ? wdata_q : 'z;
  assign dq_in    = mem_dq;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int PWRUP_CYC = 1,
  parameter int ADDR_W    = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  int unsigned since;

  always_ff @(posedge clk) begin
    if (rst) since <= 0;
    else if (since < PWRUP_CYC) since <= since + 1;
  end

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (since < PWRUP_CYC) |-> (mem_ce_n && !req_ready)); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> $stable(mem_addr)); // R3
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_ce_n) && $past(mem_we_n)) |-> rsp_valid); // R4
  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R5
  AST_WE_CE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> $rose(mem_ce_n)); // R6
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |=> mem_ce_n); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready); // R8
  AST_DRIVE_NO_OE: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> mem_oe_n); // R9
  AST_CE_NEEDS_LANE: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !(mem_lb_n && mem_ub_n)); // R10
endmodule

bind psram_ctrl psram_ctrl_chk #(.PWRUP_CYC(PWRUP_CYC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_lb_n (mem_lb_n),
  .mem_ub_n (mem_ub_n),
  .dq_oe    (dq_oe),
  .mem_addr (mem_addr)
);

// File: tb/sim_psram_ctrl.sv
module sim_psram_ctrl;
  localparam int P  = 40;
  localparam int RD = 4;
  localparam int WR = 3;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be    = '0;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  wire  [15:0]   mem_dq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  psram_ctrl #(.DEPTH_WORDS(1048576), .PWRUP_CYC(P), .RD_CYC(RD), .WR_CYC(WR)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq(mem_dq)
  );

  // Memory model: drives lanes on read, commits only on a rising strobe.
  logic [15:0] marr [256];
  logic        rd_drv;
  assign rd_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq[7:0]  = (rd_drv && !mem_lb_n) ? marr[mem_addr[7:0]][7:0]  : 8'hzz;
  assign mem_dq[15:8] = (rd_drv && !mem_ub_n) ? marr[mem_addr[7:0]][15:8] : 8'hzz;

  logic p_ce = 1'b1, p_we = 1'b1, p_lb = 1'b1, p_ub = 1'b1;
  logic [7:0] p_idx = '0;

  // Behavioural reference: cycles since acceptance on a timeline.
  logic [15:0] shadow [256];
  int   pu, t;
  bit   armed = 1'b0;
  bit   m_wr;
  logic [AW-1:0] m_addr;
  logic [15:0] m_wd, rd_expect, exp_rdata;
  logic [1:0]  m_be;
  bit   exp_ready, exp_rsp;

  function automatic int dur();
    return m_wr ? WR : RD;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pu = 0; t = -1; exp_ready = 1'b0; exp_rsp = 1'b0; exp_rdata = '0; armed = 1'b1;
      m_wr = 1'b0; m_be = '0; m_addr = '0; m_wd = '0; rd_expect = '0;
    end else begin
      exp_rsp = 1'b0;
      if (exp_ready && req_valid) begin
        if (req_be == 2'b00) begin
          if (!req_write) begin exp_rsp = 1'b1; exp_rdata = '0; end
        end else begin
          m_wr = req_write; m_addr = req_addr; m_wd = req_wdata; m_be = req_be; t = 0;
          if (req_write) begin
            if (req_be[0]) shadow[req_addr[7:0]][7:0]  = req_wdata[7:0];
            if (req_be[1]) shadow[req_addr[7:0]][15:8] = req_wdata[15:8];
          end else begin
            rd_expect = shadow[req_addr[7:0]] & {{8{req_be[1]}}, {8{req_be[0]}}};
          end
        end
      end else if (t >= 0) begin
        t++;
        if (t == dur() + 1 && !m_wr) begin exp_rsp = 1'b1; exp_rdata = rd_expect; end
        if (t == dur() + 2) t = -1;
      end
      if (pu < P) pu++;
      exp_ready = (pu >= P) && (t < 0);
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0d", tag, what, act, exp, t);
    end
  endtask

  always @(negedge clk) begin
    if (p_ce == 1'b0 && p_we == 1'b0 && (mem_ce_n || mem_we_n)) begin
      if (!p_lb) marr[p_idx][7:0]  = mem_dq[7:0];
      if (!p_ub) marr[p_idx][15:8] = mem_dq[15:8];
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_lb = mem_lb_n; p_ub = mem_ub_n; p_idx = mem_addr[7:0];

    if (armed) begin : cmp
      bit ce_low, ln_low;
      string tg;
      ce_low = (t >= 1) && (t <= dur());
      ln_low = (t >= 0) && (t <= dur());
      tg = rst ? "R2" : (pu < P) ? "R1" : (t < 0) ? "R2" : (m_wr ? "R5" : "R3");
      chk(tg, "ce_n", mem_ce_n, !ce_low);
      chk(tg, "oe_n", mem_oe_n, !(ce_low && !m_wr));
      chk(tg, "we_n", mem_we_n, !(ce_low && m_wr));
      chk("R7", "lb_n", mem_lb_n, !(ln_low && m_be[0]));
      chk("R7", "ub_n", mem_ub_n, !(ln_low && m_be[1]));
      chk((pu < P) ? "R1" : "R8", "req_ready", req_ready, exp_ready);
      chk((t < 0) ? "R10" : "R4", "rsp_valid", rsp_valid, exp_rsp);
      if (exp_rsp) chk((t < 0) ? "R10" : "R4", "rsp_rdata", rsp_rdata, exp_rdata);
      if (t >= 0 && t <= dur() + 1) chk((t == dur() + 1) ? "R6" : "R3", "mem_addr", mem_addr, m_addr);
      if (m_wr && t >= 0 && t <= dur() + 1)
        chk((t == dur() + 1) ? "R6" : "R9", "mem_dq", mem_dq, m_wd);
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin marr[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: request pending throughout the settling interval
    do_req(1'b1, 20'h00040, 16'h1111, 2'b11);
    idle(8);
    do_req(1'b1, 20'h00012, 16'hA5C3, 2'b11);
    do_req(1'b0, 20'h00012, 16'h0000, 2'b11);
    idle(3);
    // R7: single lanes
    do_req(1'b1, 20'h00012, 16'h1234, 2'b01);
    do_req(1'b1, 20'h00012, 16'h7800, 2'b10);
    do_req(1'b0, 20'h00012, 16'h0000, 2'b11);
    do_req(1'b0, 20'h00012, 16'h0000, 2'b01);
    do_req(1'b0, 20'h00012, 16'h0000, 2'b10);
    // Top address
    do_req(1'b1, 20'hFFFFF, 16'hBEEF, 2'b11);
    do_req(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
    // R10: empty mask write and reads
    do_req(1'b1, 20'h00012, 16'hDEAD, 2'b00);
    do_req(1'b0, 20'h00012, 16'h0000, 2'b00);
    do_req(1'b0, 20'h00040, 16'h0000, 2'b00);
    do_req(1'b0, 20'h00012, 16'h0000, 2'b11);
    do_req(1'b0, 20'h00040, 16'h0000, 2'b11);
    idle(12);
    if (armed) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule